// File: doc/BRIEF.md
# System Clock PLL Configuration and Lock Timer

This block is the digital control wrapper for a system clock PLL. It holds four settings: which oscillator feeds the PLL (internal RC or primary crystal), the reference pre-divider, the feedback multiplier and the post-divider. Each ratio is stored as a 3-bit code and decoded into its integer ratio through an irregular table. The decoded ratios drive the analog loop, which is modelled here only as these outputs.

A start-up timer produces a lock flag. The flag is a timeout only. It is re-armed whenever the PLL input source really changes, and it rises after a fixed number of reference clock cycles whether or not the loop has settled.

The pre-divider is loaded once from its reset default and cannot be changed while the block runs. The source, multiplier and post-divider can be rewritten at run time. A range flag reports when the selected oscillator frequency, divided by the pre-divider, falls outside the 4 to 5 MHz window that the loop needs.

Top module: `syspll_cfg`

## Requirements
- R1: Pre-divider codes 0..7 decode to ratios 1, 2, 3, 4, 5, 6, 10 and 12 on `idivRatio`.
- R2: Multiplier codes 0..7 decode to ratios 15, 16, 17, 18, 19, 20, 21 and 24 on `mulRatio`.
- R3: Post-divider codes 0..7 decode to ratios 1, 2, 4, 8, 16, 32, 64 and 256 on `odivRatio`.
- R4: The pre-divider code is taken from `dfltIdiv` while reset is asserted. A write through `idivWrEn`/`idivWrData` after reset never changes `idivRatio`.
- R5: `activeSrc` takes `dfltSrc` during reset and takes `srcWrData` on the clock edge that samples `srcWrEn`. The encoding is 0 for the internal RC oscillator and 1 for the primary oscillator.
- R6: A source write whose value differs from `activeSrc` drives `lockOk` low from that same edge.
- R7: `lockOk` rises on exactly the `LOCK_CYCLES`-th rising edge after reset is released or after an accepted source change. It then stays high until the next source change.
- R8: Writing the source value that is already active changes neither `lockOk` nor the timer.
- R9: A multiplier or post-divider write updates its ratio on the next edge and leaves `lockOk` and the timer as they were. When no write occurs, the ratio holds.
- R10: `rangeErr` is 1 exactly when the selected source frequency (`FRC_KHZ` for source 0, `POSC_KHZ` for source 1) divided by the pre-divider ratio lies outside the inclusive window `MIN_KHZ`..`MAX_KHZ`.
- R11: When a source change lands on the same edge at which the timer would expire, the change wins. `lockOk` stays low, and it rises `LOCK_CYCLES` edges after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dfltSrc | input | 1 | Reset default of the source select |
| dfltIdiv | input | 3 | Reset default pre-divider code |
| dfltMul | input | 3 | Reset default multiplier code |
| dfltOdiv | input | 3 | Reset default post-divider code |
| srcWrEn | input | 1 | Source write strobe |
| srcWrData | input | 1 | Source value to write |
| idivWrEn | input | 1 | Pre-divider write strobe (ignored) |
| idivWrData | input | 3 | Pre-divider code to write (ignored) |
| mulWrEn | input | 1 | Multiplier write strobe |
| mulWrData | input | 3 | Multiplier code to write |
| odivWrEn | input | 1 | Post-divider write strobe |
| odivWrData | input | 3 | Post-divider code to write |
| activeSrc | output | 1 | Currently selected PLL input |
| idivRatio | output | 4 | Decoded pre-divider ratio |
| mulRatio | output | 5 | Decoded multiplier ratio |
| odivRatio | output | 9 | Decoded post-divider ratio |
| lockOk | output | 1 | Start-up timer expired since the last source change |
| rangeErr | output | 1 | Loop input frequency outside its window |

## Verification
Two events can fall in the same cycle: the timer expiring and a source change that re-arms it. The bench provokes this by counting edges from a switch and landing a second switch on exactly the expiry edge. It then checks that the flag stays low and rises one full timeout later. Random traffic adds cases where a switch, a multiplier write and a post-divider write share an edge. Throughout, a bench model that counts the edges since the last re-arm judges the lock flag on every cycle.

// File: rtl/syspll_cfg_pkg.sv
package syspll_cfg_pkg;

  localparam int CODE_W = 3;
  localparam int IDIV_W = 4;
  localparam int MUL_W  = 5;
  localparam int ODIV_W = 9;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic {
    SRC_INTRC   = 1'b0,
    SRC_PRIMARY = 1'b1
  } src_e;

  // strobes from control to datapath and timer
  typedef struct packed {
    logic timerRestart;
    logic mulLoad;
    logic odivLoad;
  } strobe_t;

  function automatic logic [IDIV_W-1:0] idivRatioOf(code_t c);
    logic [IDIV_W-1:0] r;
    case (c)
      3'd6:    r = IDIV_W'(10);
      3'd7:    r = IDIV_W'(12);
      default: r = IDIV_W'(c) + IDIV_W'(1);
    endcase
    return r;
  endfunction

  function automatic logic [MUL_W-1:0] mulRatioOf(code_t c);
    logic [MUL_W-1:0] r;
    if (c == 3'd7) r = MUL_W'(24);
    else           r = MUL_W'(15) + MUL_W'(c);
    return r;
  endfunction

  function automatic logic [ODIV_W-1:0] odivRatioOf(code_t c);
    logic [ODIV_W-1:0] r;
    if (c == 3'd7) r = ODIV_W'(256);
    else           r = ODIV_W'(1) << c;
    return r;
  endfunction

endpackage

// File: rtl/syspll_lock_timer.sv
module syspll_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic lockOk
);
  localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      lockOk <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      lockOk <= 1'b0;
    end else if (!lockOk) begin
      if (cnt == LAST) lockOk <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lockOk && !restart |=> lockOk);

  p_rise_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockOk) |-> $past(cnt) == LAST);

  p_restart_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !lockOk && cnt == '0);

endmodule

// File: rtl/syspll_cfg_ctrl.sv
module syspll_cfg_ctrl
  import syspll_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    dfltSrc,
  input  logic    srcWrEn,
  input  logic    srcWrData,
  input  logic    mulWrEn,
  input  logic    odivWrEn,
  input  logic    lockOk,
  output logic    activeSrc,
  output strobe_t st
);
  src_e srcReg;
  logic srcSwitch;

  assign srcSwitch = srcWrEn && (src_e'(srcWrData) != srcReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         srcReg <= src_e'(dfltSrc);
    else if (srcSwitch) srcReg <= src_e'(srcWrData);
  end

  assign activeSrc = srcReg;

  always_comb begin
    st.timerRestart = srcSwitch;
    st.mulLoad      = mulWrEn;
    st.odivLoad     = odivWrEn;
  end

  p_src_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srcWrEn |=> activeSrc == $past(srcWrData));

  p_switch_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srcWrEn && (srcWrData != activeSrc) |=> !lockOk);

  p_same_src_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srcWrEn && (srcWrData == activeSrc) && lockOk |=> lockOk);

  p_src_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !srcWrEn |=> $stable(activeSrc));

endmodule

// File: rtl/syspll_cfg_dp.sv
module syspll_cfg_dp
  import syspll_cfg_pkg::*;
#(
  parameter int unsigned FRC_KHZ  = 8000,
  parameter int unsigned POSC_KHZ = 10000,
  parameter int unsigned MIN_KHZ  = 4000,
  parameter int unsigned MAX_KHZ  = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic              activeSrc,
  input  code_t             dfltIdiv,
  input  code_t             dfltMul,
  input  code_t             dfltOdiv,
  input  logic              idivWrEn,
  input  code_t             idivWrData,
  input  code_t             mulWrData,
  input  code_t             odivWrData,
  output logic [IDIV_W-1:0] idivRatio,
  output logic [MUL_W-1:0]  mulRatio,
  output logic [ODIV_W-1:0] odivRatio,
  output logic              rangeErr
);
  code_t idivCode, mulCode, odivCode;

  // pre-divider: reset-time load only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idivCode <= dfltIdiv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mulCode <= dfltMul;
    else if (st.mulLoad) mulCode <= mulWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           odivCode <= dfltOdiv;
    else if (st.odivLoad) odivCode <= odivWrData;
  end

  assign idivRatio = idivRatioOf(idivCode);
  assign mulRatio  = mulRatioOf(mulCode);
  assign odivRatio = odivRatioOf(odivCode);

  // window test without a divider: f/r in [lo,hi] <=> lo*r <= f <= hi*r
  logic [31:0] srcKhz, loLim, hiLim;
  always_comb begin
    srcKhz   = activeSrc ? 32'(POSC_KHZ) : 32'(FRC_KHZ);
    loLim    = 32'(MIN_KHZ) * 32'(idivRatio);
    hiLim    = 32'(MAX_KHZ) * 32'(idivRatio);
    rangeErr = (srcKhz < loLim) || (srcKhz > hiLim);
  end

  p_idiv_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idivWrEn && (idivWrData != idivCode) |=> $stable(idivRatio));

  p_mul_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !st.mulLoad |=> $stable(mulRatio));

  p_odiv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !st.odivLoad |=> $stable(odivRatio));

  p_range_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st.timerRestart |=> $stable(rangeErr));

endmodule

// File: rtl/syspll_cfg.sv
module syspll_cfg
  import syspll_cfg_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 200000,
  parameter int unsigned FRC_KHZ     = 8000,
  parameter int unsigned POSC_KHZ    = 10000,
  parameter int unsigned MIN_KHZ     = 4000,
  parameter int unsigned MAX_KHZ     = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dfltSrc,
  input  logic [2:0] dfltIdiv,
  input  logic [2:0] dfltMul,
  input  logic [2:0] dfltOdiv,
  input  logic       srcWrEn,
  input  logic       srcWrData,
  input  logic       idivWrEn,
  input  logic [2:0] idivWrData,
  input  logic       mulWrEn,
  input  logic [2:0] mulWrData,
  input  logic       odivWrEn,
  input  logic [2:0] odivWrData,
  output logic       activeSrc,
  output logic [3:0] idivRatio,
  output logic [4:0] mulRatio,
  output logic [8:0] odivRatio,
  output logic       lockOk,
  output logic       rangeErr
);
  strobe_t st;

  syspll_cfg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dfltSrc   (dfltSrc),
    .srcWrEn   (srcWrEn),
    .srcWrData (srcWrData),
    .mulWrEn   (mulWrEn),
    .odivWrEn  (odivWrEn),
    .lockOk    (lockOk),
    .activeSrc (activeSrc),
    .st        (st)
  );

  syspll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st.timerRestart),
    .lockOk  (lockOk)
  );

  syspll_cfg_dp #(
    .FRC_KHZ (FRC_KHZ),
    .POSC_KHZ(POSC_KHZ),
    .MIN_KHZ (MIN_KHZ),
    .MAX_KHZ (MAX_KHZ)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .activeSrc  (activeSrc),
    .dfltIdiv   (dfltIdiv),
    .dfltMul    (dfltMul),
    .dfltOdiv   (dfltOdiv),
    .idivWrEn   (idivWrEn),
    .idivWrData (idivWrData),
    .mulWrData  (mulWrData),
    .odivWrData (odivWrData),
    .idivRatio  (idivRatio),
    .mulRatio   (mulRatio),
    .odivRatio  (odivRatio),
    .rangeErr   (rangeErr)
  );

endmodule

// File: tb/syspll_cfg_tb.sv
module syspll_cfg_tb;
  localparam int L = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dfltSrc = 1'b0;
  logic [2:0] dfltIdiv = 3'd1, dfltMul = 3'd0, dfltOdiv = 3'd1;
  logic srcWrEn = 1'b0, srcWrData = 1'b0;
  logic idivWrEn = 1'b0, mulWrEn = 1'b0, odivWrEn = 1'b0;
  logic [2:0] idivWrData = 3'd0, mulWrData = 3'd0, odivWrData = 3'd0;
  logic activeSrc, lockOk, rangeErr;
  logic [3:0] idivRatio;
  logic [4:0] mulRatio;
  logic [8:0] odivRatio;

  always #5 clk = ~clk;

  syspll_cfg #(.LOCK_CYCLES(L)) u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  int mSrc, mIdiv, mMul, mOdiv, mSince;
  int idivTab[8] = '{1, 2, 3, 4, 5, 6, 10, 12};
  int mulTab[8]  = '{15, 16, 17, 18, 19, 20, 21, 24};
  int odivTab[8] = '{1, 2, 4, 8, 16, 32, 64, 256};

  function automatic int expRange(int src, int ratio);
    int f;
    f = (src != 0) ? 10000 : 8000;
    return ((f / ratio) < 4000 || (f / ratio) > 5000 || (f % ratio != 0 && f / ratio == 5000)) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R1 idivRatio", idivRatio, idivTab[mIdiv]);
    chk("R2 mulRatio", mulRatio, mulTab[mMul]);
    chk("R3 odivRatio", odivRatio, odivTab[mOdiv]);
    chk("R5 activeSrc", activeSrc, mSrc);
    chk("R7 lockOk", lockOk, (mSince >= L) ? 1 : 0);
    chk("R10 rangeErr", rangeErr, expRange(mSrc, idivTab[mIdiv]));
  endtask

  task automatic step();
    @(posedge clk);
    if (srcWrEn && (int'(srcWrData) != mSrc)) begin
      mSrc = srcWrData;
      mSince = 0;
    end else if (mSince < L) mSince++;
    if (mulWrEn)  mMul  = mulWrData;
    if (odivWrEn) mOdiv = odivWrData;
    @(negedge clk);
    compareAll();
    srcWrEn = 1'b0; mulWrEn = 1'b0; odivWrEn = 1'b0; idivWrEn = 1'b0;
  endtask

  task automatic doReset(int s, int i, int m, int o);
    @(negedge clk);
    rst_n = 1'b0;
    dfltSrc = s[0]; dfltIdiv = 3'(i); dfltMul = 3'(m); dfltOdiv = 3'(o);
    repeat (2) @(negedge clk);
    mSrc = s; mIdiv = i; mMul = m; mOdiv = o; mSince = 0;
    chk("R7 lockOk in reset", lockOk, 0);
    rst_n = 1'b1;
    compareAll();
  endtask

  task automatic switchSrc();
    srcWrEn = 1'b1;
    srcWrData = ~activeSrc;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    doReset(0, 1, 0, 1);
    // R7: lock rises on the L-th edge after release
    repeat (L - 1) step();
    chk("R7 low before limit", lockOk, 0);
    step();
    chk("R7 high at limit", lockOk, 1);

    // R2, R3 tables through writes
    for (int c = 0; c < 8; c++) begin
      mulWrEn = 1'b1; mulWrData = 3'(c);
      odivWrEn = 1'b1; odivWrData = 3'(7 - c);
      step();
      chk("R9 lock untouched by ratio write", lockOk, 1);
    end

    // R8: same-source write
    srcWrEn = 1'b1; srcWrData = activeSrc;
    step();
    chk("R8 same source keeps lock", lockOk, 1);

    // R4: pre-divider writes ignored
    for (int c = 0; c < 8; c++) begin
      idivWrEn = 1'b1; idivWrData = 3'(c);
      step();
      chk("R4 idiv write ignored", idivRatio, 2);
    end

    // R6 with R9: switch together with multiplier write
    srcWrEn = 1'b1; srcWrData = ~activeSrc;
    mulWrEn = 1'b1; mulWrData = 3'd7;
    step();
    chk("R6 switch clears lock", lockOk, 0);
    chk("R9 mul with switch", mulRatio, 24);

    // back-to-back switches
    repeat (3) step();
    switchSrc();
    chk("R6 second switch", lockOk, 0);
    repeat (L - 1) step();
    chk("R7 back-to-back still low", lockOk, 0);
    step();
    chk("R7 back-to-back high", lockOk, 1);

    // R11: switch on the expiry edge
    switchSrc();
    repeat (L - 1) step();
    chk("R11 low before collision", lockOk, 0);
    switchSrc();
    chk("R11 switch beats expiry", lockOk, 0);
    repeat (L - 1) step();
    chk("R11 still low", lockOk, 0);
    step();
    chk("R11 rises after full rearm", lockOk, 1);

    // R1, R10: every pre-divider default on both sources
    for (int c = 0; c < 8; c++) begin
      doReset(c % 2, c, c, c);
      chk("R1 idiv default", idivRatio, idivTab[c]);
      step();
      switchSrc();
      chk("R10 range other source", rangeErr, expRange(mSrc, idivTab[c]));
    end

    // random traffic
    doReset(1, 1, 3, 2);
    for (int n = 0; n < 800; n++) begin
      srcWrEn   = ($urandom % 12) == 0;
      srcWrData = 1'($urandom);
      mulWrEn   = ($urandom % 3) == 0;
      mulWrData = 3'($urandom);
      odivWrEn  = ($urandom % 3) == 0;
      odivWrData = 3'($urandom);
      idivWrEn  = ($urandom % 4) == 0;
      idivWrData = 3'($urandom);
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule